// File: doc/BRIEF.md
# Interrupt and Status Reporting Controller

This block holds the status, interrupt-cause and sequence-step registers of a SCSI host adapter register file and drives its single level interrupt line. Command logic elsewhere in the adapter posts events through one-cycle request pulses:
- a generic raise that carries its own cause, status and step values;
- a DMA-done event;
- a command-completion event with a status byte;
- a bus-reset command.

The host reads the registers through a byte-wide read port. A strobed read of the cause register returns the cause and then clears it. The same read also clears the related status bits and drops the interrupt.

The block queues one command-completion event. If a completion arrives while an interrupt is still unacknowledged, it is parked. It is then reported automatically by the read that acknowledges the earlier interrupt, so the host never loses a completion that lands on top of another interrupt. A small write port loads the FIFO-flags register and the first configuration register. Bit 6 of that configuration register suppresses the interrupt for bus-reset commands.

Top module: `isr_ctrl`

## Requirements
- R1: After reset the status, cause, sequence-step and FIFO-flags registers read 0, the configuration register reads 8'h07, and `irq_o` is low.
- R2: A raise request loads status bits 6:0, the cause byte and the step, and sets status bit 7 (interrupt pending) and `irq_o` at the next edge. A repeated raise while pending keeps `irq_o` high.
- R3: A strobed read of select 1 (cause) returns the current cause. At the next edge the block clears the cause to 0, clears status bit 4 (count zero) and bit 7, sets the step to 4 (command done) and drops `irq_o`.
- R4: A read without `rd_stb`, or a strobed read of any select other than 1, changes no register and leaves `irq_o` as it was.
- R5: A completion that arrives while status bit 7 is set is held. Status, cause and `irq_o` do not change.
- R6: A cause-clearing read made while a completion is held reports that completion at the same edge. Status becomes 8'h93 (pending, count zero, phase 3 = status phase), the cause becomes 8'h10 (bus service), the step becomes 0, `irq_o` stays high and `cmpl_status_o` shows the held status byte.
- R7: A completion that arrives with status bit 7 clear is reported at the next edge, with the same register values as R6 and its own status byte on `cmpl_status_o`.
- R8: A bus-reset command sets the cause to 8'h80. It sets bit 7 and raises `irq_o` only when configuration bit 6 is 0.
- R9: A DMA-done event ORs 8'h90 into the status register, sets the cause to 8'h10, zeroes the step and FIFO flags, and pulses `tc_clear_o` for one cycle.
- R10: When a raise request and a cause-clearing read fall in the same cycle, the raise wins: `irq_o` stays high and the cause holds the new value.
- R11: Read selects are 0 status, 1 cause, 2 step (zero-extended), 3 FIFO flags and 4 configuration. Writes take effect only for select 3 or 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| rd_stb | input | 1 | Read strobe that enables read side effects |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data for `rd_sel`, combinational |
| wr_stb | input | 1 | Write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| ev_raise | input | 1 | Generic interrupt raise request |
| ev_cause | input | 8 | Cause byte for a raise |
| ev_stat | input | 8 | Status bits 6:0 for a raise |
| ev_seq | input | 3 | Sequence step for a raise |
| ev_dma_done | input | 1 | DMA-done event |
| ev_cmpl | input | 1 | Command-completion event |
| ev_cmpl_status | input | 8 | Status byte carried by the completion |
| ev_busrst | input | 1 | Bus-reset command |
| irq_o | output | 1 | Level interrupt, registered |
| cmpl_status_o | output | 8 | Status byte of the last reported completion |
| tc_clear_o | output | 1 | One-cycle pulse that clears the transfer counter |

## Verification
On every cycle, the assertions check these edge-to-edge relations:
- a clearing read with nothing else pending drops the interrupt;
- a raise beats a clearing read in the same cycle;
- a masked bus reset leaves the line low;
- a held completion leaves the interrupt and cause untouched;
- DMA done is followed by the counter-clear pulse.

Only the bench scenarios can show the values that must come back from the registers:
- the exact status and cause bytes after a deferred report;
- the value returned by the clearing read itself;
- the reset contents;
- that a read without a strobe has no side effect.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int DATA_W = 8;
  localparam int SEQ_W  = 3;
  localparam int SEL_W  = 3;

  localparam int BIT_INT   = 7;
  localparam int BIT_TC    = 4;
  localparam int CFG_NOREP = 6;

  localparam logic [DATA_W-1:0] CAUSE_BUS_SVC = 8'h10;
  localparam logic [DATA_W-1:0] CAUSE_BUS_RST = 8'h80;
  localparam logic [DATA_W-1:0] CFG_RESET_VAL = 8'h07;
  localparam logic [DATA_W-1:0] PHASE_STATUS  = 8'h03;
  localparam logic [SEQ_W-1:0]  STEP_DONE     = 3'd4;

  typedef enum logic [SEL_W-1:0] {
    SEL_STAT  = 3'd0,
    SEL_CAUSE = 3'd1,
    SEL_STEP  = 3'd2,
    SEL_FLAGS = 3'd3,
    SEL_CFG   = 3'd4
  } reg_sel_e;

  // Status after a transfer completes: count-zero and pending ORed in.
  function automatic logic [DATA_W-1:0] done_status(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] m;
    m = '0;
    m[BIT_TC]  = 1'b1;
    m[BIT_INT] = 1'b1;
    return s | m;
  endfunction

  // Status loaded by a generic raise: caller bits below pending, pending set.
  function automatic logic [DATA_W-1:0] raise_status(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = s;
    r[BIT_INT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/isr_access.sv
module isr_access
  import isr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEQ_W,
  parameter int AW = SEL_W
) (
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_sel,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] stat_q,
  input  logic [DW-1:0] cause_q,
  input  logic [SW-1:0] step_q,
  input  logic [DW-1:0] flags_q,
  input  logic [DW-1:0] cfg_q,
  output logic [DW-1:0] rd_data,
  output logic          clr_req,
  output logic          wr_flags,
  output logic          wr_cfg
);
  localparam int PADW = DW - SW;

  always_comb begin
    unique case (rd_sel)
      SEL_STAT:  rd_data = stat_q;
      SEL_CAUSE: rd_data = cause_q;
      SEL_STEP:  rd_data = {{PADW{1'b0}}, step_q};
      SEL_FLAGS: rd_data = flags_q;
      SEL_CFG:   rd_data = cfg_q;
      default:   rd_data = '0;
    endcase
  end

  assign clr_req  = rd_stb && (rd_sel == SEL_CAUSE);
  assign wr_flags = wr_stb && (wr_sel == SEL_FLAGS);
  assign wr_cfg   = wr_stb && (wr_sel == SEL_CFG);
endmodule

// File: rtl/isr_defer.sv
module isr_defer
  import isr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          consume,
  input  logic [DW-1:0] status_in,
  output logic          valid,
  output logic [DW-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      status_q <= '0;
    end else if (capture) begin
      valid    <= 1'b1;
      status_q <= status_in;
    end else if (consume) begin
      valid    <= 1'b0;
    end
  end

  // R5: a held completion is only taken by a clearing read
  p_hold_until_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !consume && !capture) |=> valid);
endmodule

// File: rtl/isr_core.sv
module isr_core
  import isr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEQ_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_req,
  input  logic          wr_flags,
  input  logic          wr_cfg,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_raise,
  input  logic [DW-1:0] ev_cause,
  input  logic [DW-1:0] ev_stat,
  input  logic [SW-1:0] ev_seq,
  input  logic          ev_dma_done,
  input  logic          ev_cmpl,
  input  logic [DW-1:0] ev_cmpl_status,
  input  logic          ev_busrst,
  input  logic          defer_valid,
  input  logic [DW-1:0] defer_status,
  output logic          defer_capture,
  output logic          defer_take,
  output logic [DW-1:0] stat_q,
  output logic [DW-1:0] cause_q,
  output logic [SW-1:0] step_q,
  output logic [DW-1:0] flags_q,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] cmpl_q,
  output logic          tcclr_q
);
  logic [DW-1:0] stat_n, cause_n, flags_n, cfg_n, cmpl_n;
  logic [SW-1:0] step_n;
  logic          tcclr_n;
  logic          pending;
  logic          cmpl_now;
  logic          report_evt;
  logic          any_evt;

  assign pending       = stat_q[BIT_INT];
  assign cmpl_now      = ev_cmpl && !pending;
  assign defer_capture = ev_cmpl && pending;
  assign defer_take    = clr_req && defer_valid;
  assign report_evt    = defer_take || cmpl_now;
  assign any_evt       = ev_raise || ev_dma_done || ev_cmpl || ev_busrst;

  // Later assignments win: clear < bus reset < completion < DMA done < raise.
  always_comb begin
    stat_n  = stat_q;
    cause_n = cause_q;
    step_n  = step_q;
    flags_n = flags_q;
    cfg_n   = cfg_q;
    cmpl_n  = cmpl_q;
    tcclr_n = 1'b0;
    if (wr_flags) flags_n = wr_data;
    if (wr_cfg)   cfg_n   = wr_data;
    if (clr_req) begin
      cause_n          = '0;
      stat_n[BIT_TC]   = 1'b0;
      stat_n[BIT_INT]  = 1'b0;
      step_n           = STEP_DONE;
    end
    if (ev_busrst) begin
      cause_n = CAUSE_BUS_RST;
      if (!cfg_q[CFG_NOREP]) stat_n[BIT_INT] = 1'b1;
    end
    if (report_evt) begin
      stat_n  = done_status(PHASE_STATUS);
      cause_n = CAUSE_BUS_SVC;
      step_n  = '0;
      flags_n = '0;
      tcclr_n = 1'b1;
      cmpl_n  = defer_take ? defer_status : ev_cmpl_status;
    end
    if (ev_dma_done) begin
      stat_n  = done_status(stat_n);
      cause_n = CAUSE_BUS_SVC;
      step_n  = '0;
      flags_n = '0;
      tcclr_n = 1'b1;
    end
    if (ev_raise) begin
      stat_n  = raise_status(ev_stat);
      cause_n = ev_cause;
      step_n  = ev_seq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      cause_q <= '0;
      step_q  <= '0;
      flags_q <= '0;
      cfg_q   <= CFG_RESET_VAL;
      cmpl_q  <= '0;
      tcclr_q <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      cause_q <= cause_n;
      step_q  <= step_n;
      flags_q <= flags_n;
      cfg_q   <= cfg_n;
      cmpl_q  <= cmpl_n;
      tcclr_q <= tcclr_n;
    end
  end

  // R3: a plain clearing read drops the pending bit
  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !defer_valid && !any_evt) |=> !stat_q[BIT_INT]);
  // R10: raise beats clear in the same cycle
  p_raise_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && ev_raise) |=> (stat_q[BIT_INT] && cause_q == $past(ev_cause)));
  // R8: masked bus reset leaves a clear line clear
  p_busrst_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_busrst && cfg_q[CFG_NOREP] && !pending && !ev_raise && !ev_dma_done && !ev_cmpl)
      |=> !stat_q[BIT_INT]);
  // R5: a held completion changes neither cause nor pending
  p_defer_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (defer_capture && !clr_req && !ev_raise && !ev_dma_done && !ev_busrst)
      |=> ($stable(cause_q) && stat_q[BIT_INT]));
  // R9: DMA done is followed by the counter-clear pulse
  p_tc_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dma_done |=> tcclr_q);
endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int SW = SEQ_W,
  parameter int AW = SEL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          ev_raise,
  input  logic [DW-1:0] ev_cause,
  input  logic [DW-1:0] ev_stat,
  input  logic [SW-1:0] ev_seq,
  input  logic          ev_dma_done,
  input  logic          ev_cmpl,
  input  logic [DW-1:0] ev_cmpl_status,
  input  logic          ev_busrst,
  output logic          irq_o,
  output logic [DW-1:0] cmpl_status_o,
  output logic          tc_clear_o
);
  logic [DW-1:0] stat_q, cause_q, flags_q, cfg_q, defer_status;
  logic [SW-1:0] step_q;
  logic          clr_req, wr_flags, wr_cfg;
  logic          defer_valid, defer_capture, defer_take;

  isr_access #(.DW(DW), .SW(SW), .AW(AW)) u_access (
    .rd_stb(rd_stb), .rd_sel(rd_sel), .wr_stb(wr_stb), .wr_sel(wr_sel),
    .stat_q(stat_q), .cause_q(cause_q), .step_q(step_q), .flags_q(flags_q),
    .cfg_q(cfg_q), .rd_data(rd_data), .clr_req(clr_req),
    .wr_flags(wr_flags), .wr_cfg(wr_cfg)
  );

  isr_defer #(.DW(DW)) u_defer (
    .clk(clk), .rst_n(rst_n), .capture(defer_capture), .consume(defer_take),
    .status_in(ev_cmpl_status), .valid(defer_valid), .status_q(defer_status)
  );

  isr_core #(.DW(DW), .SW(SW)) u_core (
    .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .wr_flags(wr_flags),
    .wr_cfg(wr_cfg), .wr_data(wr_data), .ev_raise(ev_raise),
    .ev_cause(ev_cause), .ev_stat(ev_stat), .ev_seq(ev_seq),
    .ev_dma_done(ev_dma_done), .ev_cmpl(ev_cmpl),
    .ev_cmpl_status(ev_cmpl_status), .ev_busrst(ev_busrst),
    .defer_valid(defer_valid), .defer_status(defer_status),
    .defer_capture(defer_capture), .defer_take(defer_take),
    .stat_q(stat_q), .cause_q(cause_q), .step_q(step_q), .flags_q(flags_q),
    .cfg_q(cfg_q), .cmpl_q(cmpl_status_o), .tcclr_q(tc_clear_o)
  );

  assign irq_o = stat_q[BIT_INT];

  // R6: a deferred report keeps the line up across the acknowledging read
  p_defer_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_take |=> irq_o);
endmodule

// File: tb/isr_ctrl_bench.sv
module isr_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [2:0] rd_sel = 3'd0, wr_sel = 3'd0;
  logic [7:0] rd_data, wr_data = 8'h00;
  logic       ev_raise = 1'b0, ev_dma_done = 1'b0, ev_cmpl = 1'b0, ev_busrst = 1'b0;
  logic [7:0] ev_cause = 8'h00, ev_stat = 8'h00, ev_cmpl_status = 8'h00;
  logic [2:0] ev_seq = 3'd0;
  logic       irq_o, tc_clear_o;
  logic [7:0] cmpl_status_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  isr_ctrl u_isr_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
    .wr_stb(wr_stb), .wr_sel(wr_sel), .wr_data(wr_data), .ev_raise(ev_raise),
    .ev_cause(ev_cause), .ev_stat(ev_stat), .ev_seq(ev_seq),
    .ev_dma_done(ev_dma_done), .ev_cmpl(ev_cmpl), .ev_cmpl_status(ev_cmpl_status),
    .ev_busrst(ev_busrst), .irq_o(irq_o), .cmpl_status_o(cmpl_status_o),
    .tc_clear_o(tc_clear_o)
  );

  // Ops: 0 raise(cause=arg, stat=01, step=3), 1 DMA done, 2 completion(arg),
  //      3 bus reset, 4 strobed cause read (expect rd), 5 config write(arg)
  // Layout: op(4) arg(8) rd(8) stat(8) cause(8) irq(4)
  localparam int NV = 14;
  localparam logic [39:0] VEC [NV] = '{
    40'h0_18_00_81_18_1,  // R2 raise
    40'h0_08_00_81_08_1,  // R2 repeated raise
    40'h4_00_08_01_00_0,  // R3 clearing read
    40'h1_00_00_91_10_1,  // R9 DMA done
    40'h2_02_00_91_10_1,  // R5 completion held
    40'h4_00_10_93_10_1,  // R6 deferred report
    40'h4_00_10_03_00_0,  // R3 acknowledge
    40'h2_05_00_93_10_1,  // R7 immediate completion
    40'h4_00_10_03_00_0,  // R3
    40'h3_00_00_83_80_1,  // R8 bus reset reported
    40'h4_00_80_03_00_0,  // R3
    40'h5_47_00_03_00_0,  // R11 config write
    40'h3_00_00_03_80_0,  // R8 bus reset masked
    40'h4_00_80_03_00_0   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [2:0] sel, output logic [7:0] val);
    rd_stb = 1'b0; rd_sel = sel; #1; val = rd_data;
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] arg, output logic [7:0] rd);
    @(negedge clk);
    rd = 8'h00;
    case (op)
      4'd0: begin ev_raise = 1; ev_cause = arg; ev_stat = 8'h01; ev_seq = 3'd3; end
      4'd1: ev_dma_done = 1;
      4'd2: begin ev_cmpl = 1; ev_cmpl_status = arg; end
      4'd3: ev_busrst = 1;
      4'd4: begin rd_stb = 1; rd_sel = 3'd1; #1; rd = rd_data; end
      default: begin wr_stb = 1; wr_sel = 3'd4; wr_data = arg; end
    endcase
    @(negedge clk);
    ev_raise = 0; ev_dma_done = 0; ev_cmpl = 0; ev_busrst = 0; rd_stb = 0; wr_stb = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, rdv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state, R11 select map
    peek(3'd0, v); chk("R1 status", v, 8'h00);
    peek(3'd1, v); chk("R1 cause", v, 8'h00);
    peek(3'd2, v); chk("R1 step", v, 8'h00);
    peek(3'd3, v); chk("R1 flags", v, 8'h00);
    peek(3'd4, v); chk("R1 cfg", v, 8'h07);
    chk("R1 irq", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [39:0] e;
      e = VEC[i];
      do_op(e[39:36], e[35:28], rdv);
      if (e[39:36] == 4'd4) chk($sformatf("R3 vec%0d read value", i), rdv, e[27:20]);
      peek(3'd0, v); chk($sformatf("R2 vec%0d status", i), v, e[19:12]);
      peek(3'd1, v); chk($sformatf("R2 vec%0d cause", i), v, e[11:4]);
      chk($sformatf("R2 vec%0d irq", i), {7'd0, irq_o}, {4'd0, e[3:0]});
      if (i == 5) chk("R6 reported status byte", cmpl_status_o, 8'h02);
      if (i == 5) begin peek(3'd2, v); chk("R6 step", v, 8'h00); end
      if (i == 6) begin peek(3'd2, v); chk("R3 step done", v, 8'h04); end
      if (i == 7) chk("R7 reported status byte", cmpl_status_o, 8'h05);
    end

    // R9: flags zeroed and counter-clear pulse
    @(negedge clk); wr_stb = 1; wr_sel = 3'd3; wr_data = 8'h05;
    @(negedge clk); wr_stb = 0;
    peek(3'd3, v); chk("R11 flags write", v, 8'h05);
    do_op(4'd1, 8'h00, rdv);
    chk("R9 tc_clear pulse", {7'd0, tc_clear_o}, 8'h01);
    peek(3'd3, v); chk("R9 flags zeroed", v, 8'h00);
    peek(3'd2, v); chk("R9 step zeroed", v, 8'h00);
    @(negedge clk);
    chk("R9 pulse one cycle", {7'd0, tc_clear_o}, 8'h00);

    // R4: unstrobed cause read and strobed read of another select have no effect
    peek(3'd1, v);
    @(negedge clk); rd_stb = 1; rd_sel = 3'd0;
    @(negedge clk); rd_stb = 0;
    peek(3'd1, v); chk("R4 cause kept", v, 8'h10);
    chk("R4 irq kept", {7'd0, irq_o}, 8'h01);

    // R10: raise and clearing read together
    @(negedge clk);
    rd_stb = 1; rd_sel = 3'd1; ev_raise = 1; ev_cause = 8'h20; ev_stat = 8'h00; ev_seq = 3'd1;
    @(negedge clk); rd_stb = 0; ev_raise = 0;
    chk("R10 irq stays", {7'd0, irq_o}, 8'h01);
    peek(3'd1, v); chk("R10 cause new", v, 8'h20);

    // R1: hardware reset restores configuration
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    peek(3'd4, v); chk("R1 cfg after reset", v, 8'h07);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule